// File: doc/BRIEF.md
# Overcurrent Circuit Breaker Timer

This block is the digital decision logic behind one channel of an electronic circuit breaker. An analog current limiter elsewhere clamps the channel current and raises a synchronous flag, `oc_active`, while it is limiting. The block watches that flag against a one-microsecond timebase, `us_tick`. It latches the power switch off only when overcurrent persists or repeats in a specific pattern.

When the channel is turned on, a `start` pulse opens a start-up blanking phase. The breaker cannot trip during this phase, but it trips if the limiter is still active when the phase ends. After start-up, overcurrent bursts shorter than a qualification time are filtered out. A qualified burst does not trip the breaker. It opens a blanking delay, which is followed by an armed window. Only a second qualified burst inside the armed window trips the breaker. A quiet armed window sends the block back to idle.

A tripped channel holds its fault output active and its gate-kill command asserted. It stays that way until one of three things happens: the enable is held inactive long enough, an undervoltage clear arrives, or, in retry mode, a cool-down period elapses and a fresh start-up begins. All durations are parameters counted in `us_tick` pulses. Only cycles with `us_tick` high advance any timer.

Top module: `ocb_breaker`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `fault_n` is 1 and `gate_kill` is 0.
- R2: A `start` pulse while `gate_req` is high and the channel is not tripped moves `state_o` to 4 (start-up) for STARTUP_US ticks. At the last tick the block trips if `oc_active` is high, and otherwise it returns to 0.
- R3: Outside start-up, `oc_active` held for fewer than QUAL_US consecutive ticks has no lasting effect. While the burst is pending, `state_o` reads 1 (qualify). Dropping the flag returns the block to 0 and restarts the count from zero.
- R4: A burst reaching QUAL_US ticks from idle or qualify moves `state_o` to 2 (blank) for BLANK_US ticks. No trip can occur during the blank phase, whatever `oc_active` does.
- R5: After the blank phase, `state_o` is 3 (armed) for ARM_US ticks. A burst counted from zero that reaches QUAL_US ticks inside this window trips the breaker.
- R6: If the armed window expires without a qualified burst, `state_o` returns to 0, and shorter bursts inside the window do not trip.
- R7: A trip sets `state_o` to 5, `fault_n` to 0 and `gate_kill` to 1. These hold, and a `start` pulse is ignored, until the trip is cleared.
- R8: `gate_req` held low for OFF_US consecutive ticks while tripped clears the trip and returns to 0. A shorter low period leaves the trip in place.
- R9: `uv_clr` high at a clock edge forces `state_o` to 0 at that edge, from any state.
- R10: With `retry_mode` high, a trip clears itself after COOL_US ticks and enters start-up (4). With `retry_mode` low, the trip never expires.
- R11: `gate_req` low in any untripped state returns `state_o` to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle timebase pulse, once per microsecond |
| oc_active | input | 1 | Current limiter active, synchronous |
| gate_req | input | 1 | Channel enable, high requests the switch on |
| start | input | 1 | One-cycle pulse marking gate turn-on |
| uv_clr | input | 1 | Supply undervoltage clear |
| retry_mode | input | 1 | 1 = automatic retry after cool-down, 0 = stay tripped |
| fault_n | output | 1 | Fault flag, low while tripped |
| gate_kill | output | 1 | Gate-off command, high while tripped |
| state_o | output | 3 | Phase: 0 idle, 1 qualify, 2 blank, 3 armed, 4 start-up, 5 tripped |

## Verification
The bench runs a small configuration of the block. It stops one tick short of every duration and then one tick at it, so any off-by-one in a timer shows up as a phase ending early or late. It places a burst one tick short of qualification both in idle and inside the armed window. A design that failed to restart the qualification count on a dropout would trip or blank there. A design that carried a burst through the blank phase would trip too early. It also releases the enable one tick short of the clear time, which exposes a clear counter that does not restart. Finally, it runs the same trip with retry on and off to catch a cool-down that fires in the wrong mode.

// File: rtl/ocb_pkg.sv
package ocb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_QUAL  = 3'd1,
    ST_BLANK = 3'd2,
    ST_ARMED = 3'd3,
    ST_START = 3'd4,
    ST_LATCH = 3'd5
  } ocb_state_e;

  // Bits needed to hold the values 0 .. n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ocb_run_filter.sv
// Counts consecutive ticks with level high; pulses hit on the LEN-th one.
module ocb_run_filter #(
  parameter int unsigned LEN = 100,
  parameter int unsigned W   = ocb_pkg::cnt_width(LEN)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         level,
  input  logic         clr,
  output logic         hit,
  output logic [W-1:0] run
);

  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt_q;

  assign hit = tick && level && !clr && (cnt_q == LAST);
  assign run = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || !level || hit) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: the run counter never passes its completion value
  p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R3: a dropout always leaves the count at zero
  p_run_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !level |=> (cnt_q == '0));

endmodule

// File: rtl/ocb_phase_timer.sv
// Tick counter for the current phase; done fires on the tick reaching last.
module ocb_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic [W-1:0] last,
  output logic         done
);

  logic [W-1:0] cnt_q;

  assign done = tick && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != last)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: the phase count stays inside the window of the active phase
  p_phase_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);

endmodule

// File: rtl/ocb_breaker.sv
module ocb_breaker
  import ocb_pkg::*;
#(
  parameter int unsigned QUAL_US    = 100,
  parameter int unsigned BLANK_US   = 5000,
  parameter int unsigned ARM_US     = 5000,
  parameter int unsigned STARTUP_US = 5000,
  parameter int unsigned COOL_US    = 4000000,
  parameter int unsigned OFF_US     = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       oc_active,
  input  logic       gate_req,
  input  logic       start,
  input  logic       uv_clr,
  input  logic       retry_mode,
  output logic       fault_n,
  output logic       gate_kill,
  output logic [2:0] state_o
);

  localparam int unsigned TMAX = max_of(max_of(BLANK_US, ARM_US), max_of(STARTUP_US, COOL_US));
  localparam int unsigned TW   = cnt_width(TMAX);
  localparam int unsigned QW   = cnt_width(QUAL_US);
  localparam int unsigned OW   = cnt_width(OFF_US);

  ocb_state_e state_q, state_d;

  // Named internal events
  logic          oc_hit;      // qualified overcurrent burst completed
  logic          off_hit;     // enable low long enough to clear a trip
  logic          phase_done;  // current phase duration elapsed
  logic          phase_clr;   // phase timer restarts
  logic          qual_clr;
  logic          start_ok;
  logic [TW-1:0] phase_last;
  logic [QW-1:0] qual_run;
  logic [OW-1:0] off_run;

  assign qual_clr = !gate_req ||
                    !((state_q == ST_IDLE) || (state_q == ST_QUAL) || (state_q == ST_ARMED));

  ocb_run_filter #(.LEN(QUAL_US), .W(QW)) u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (us_tick),
    .level (oc_active),
    .clr   (qual_clr),
    .hit   (oc_hit),
    .run   (qual_run)
  );

  ocb_run_filter #(.LEN(OFF_US), .W(OW)) u_off (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (us_tick),
    .level (!gate_req),
    .clr   (state_q != ST_LATCH),
    .hit   (off_hit),
    .run   (off_run)
  );

  always_comb begin
    case (state_q)
      ST_BLANK: phase_last = TW'(BLANK_US - 1);
      ST_ARMED: phase_last = TW'(ARM_US - 1);
      ST_START: phase_last = TW'(STARTUP_US - 1);
      ST_LATCH: phase_last = TW'(COOL_US - 1);
      default:  phase_last = '0;
    endcase
  end

  ocb_phase_timer #(.W(TW)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (us_tick),
    .clr   (phase_clr),
    .last  (phase_last),
    .done  (phase_done)
  );

  assign start_ok = start && gate_req && !uv_clr && (state_q != ST_LATCH);

  always_comb begin
    state_d = state_q;
    if (uv_clr) begin
      state_d = ST_IDLE;
    end else if (state_q == ST_LATCH) begin
      if (off_hit)                        state_d = ST_IDLE;
      else if (retry_mode && phase_done)  state_d = ST_START;
    end else if (!gate_req) begin
      state_d = ST_IDLE;
    end else if (start) begin
      state_d = ST_START;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (oc_hit)         state_d = ST_BLANK;
          else if (oc_active) state_d = ST_QUAL;
        end
        ST_QUAL: begin
          if (oc_hit)          state_d = ST_BLANK;
          else if (!oc_active) state_d = ST_IDLE;
        end
        ST_BLANK: if (phase_done) state_d = ST_ARMED;
        ST_ARMED: begin
          if (oc_hit)          state_d = ST_LATCH;
          else if (phase_done) state_d = ST_IDLE;
        end
        ST_START: if (phase_done) state_d = oc_active ? ST_LATCH : ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign phase_clr = (state_d != state_q) || start_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign fault_n   = (state_q != ST_LATCH);
  assign gate_kill = (state_q == ST_LATCH);

  // R4: the blank phase never leads straight to a trip
  p_blank_no_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLANK) |=> (state_q != ST_LATCH));

  // R5: a trip is entered only from the armed window or from start-up
  p_trip_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_kill) |-> ($past(state_q) == ST_ARMED || $past(state_q) == ST_START));

  // R6: leaving the armed window for idle with the enable up needs an elapsed window
  p_armed_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && gate_req && !uv_clr && !start && !oc_hit && !phase_done)
      |=> (state_q == ST_ARMED));

  // R7: while tripped and no clear source is present, the trip holds
  p_trip_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_kill && !uv_clr && !off_hit && !retry_mode) |=> !fault_n);

  // R9: the undervoltage clear always lands in idle
  p_uv_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uv_clr |=> (state_q == ST_IDLE));

endmodule

// File: tb/ocb_breaker_tb.sv
module ocb_breaker_tb;

  localparam int unsigned Q = 4;
  localparam int unsigned B = 10;
  localparam int unsigned A = 8;
  localparam int unsigned S = 12;
  localparam int unsigned C = 30;
  localparam int unsigned O = 3;

  logic clk = 1'b0;
  logic rst_n, us_tick, oc_active, gate_req, start, uv_clr, retry_mode;
  logic fault_n, gate_kill;
  logic [2:0] state_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ocb_breaker #(
    .QUAL_US(Q), .BLANK_US(B), .ARM_US(A), .STARTUP_US(S), .COOL_US(C), .OFF_US(O)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .oc_active(oc_active),
    .gate_req(gate_req), .start(start), .uv_clr(uv_clr), .retry_mode(retry_mode),
    .fault_n(fault_n), .gate_kill(gate_kill), .state_o(state_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      us_tick = 1'b1; cyc();
      us_tick = 1'b0; cyc();
    end
  endtask

  task automatic pulse_start();
    start = 1'b1; cyc(); start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; us_tick = 0; oc_active = 0; gate_req = 0; start = 0; uv_clr = 0; retry_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1 state", state_o, 0); chk("R1 fault_n", fault_n, 1); chk("R1 gate_kill", gate_kill, 0);

    // R2 clean start-up
    gate_req = 1; pulse_start();
    chk("R2 enter", state_o, 4);
    step(S - 1); chk("R2 hold", state_o, 4);
    step(1);     chk("R2 end idle", state_o, 0);

    // R3 glitch filter and restart
    oc_active = 1; cyc(); chk("R3 qualify", state_o, 1);
    step(Q - 1); chk("R3 short", state_o, 1);
    oc_active = 0; cyc(); chk("R3 drop", state_o, 0);
    oc_active = 1; cyc(); step(Q - 1); chk("R3 restart", state_o, 1);
    step(1); chk("R4 enter blank", state_o, 2);

    // R4 blank ignores overcurrent, R5 armed trip
    step(B - 1); chk("R4 blank hold", state_o, 2);
    step(1);     chk("R5 armed", state_o, 3);
    step(Q - 1); chk("R5 pending", state_o, 3);
    step(1);     chk("R5 trip", state_o, 5);
    chk("R7 fault_n", fault_n, 0); chk("R7 gate_kill", gate_kill, 1);
    pulse_start(); chk("R7 start ignored", state_o, 5);
    oc_active = 0;

    // R8 clear by enable low
    gate_req = 0; step(O - 1); gate_req = 1; cyc(); chk("R8 short off", state_o, 5);
    gate_req = 0; step(O - 1); chk("R8 pending", state_o, 5);
    step(1); chk("R8 cleared", state_o, 0); chk("R8 fault_n", fault_n, 1);

    // R6 armed window expiry with a short burst inside
    gate_req = 1; oc_active = 1; cyc(); step(Q); oc_active = 0;
    chk("R6 blank", state_o, 2);
    step(B); chk("R6 armed", state_o, 3);
    step(1); oc_active = 1; step(Q - 1); oc_active = 0; cyc();
    chk("R6 short burst", state_o, 3);
    step(A - Q - 1); chk("R6 window hold", state_o, 3);
    step(1); chk("R6 expired", state_o, 0);

    // R11 enable low in armed
    oc_active = 1; cyc(); step(Q); oc_active = 0; step(B);
    chk("R11 armed", state_o, 3);
    gate_req = 0; cyc(); chk("R11 idle", state_o, 0);

    // R2 trip at end of start-up, R9 undervoltage clear
    gate_req = 1; pulse_start(); oc_active = 1; step(S);
    chk("R2 startup trip", state_o, 5);
    uv_clr = 1; cyc(); uv_clr = 0; chk("R9 uv clear", state_o, 0);
    oc_active = 0; cyc();

    // R10 auto-retry
    retry_mode = 1; pulse_start(); oc_active = 1; step(S); oc_active = 0;
    chk("R10 tripped", state_o, 5);
    step(C - 1); chk("R10 cooling", state_o, 5);
    step(1);     chk("R10 retry", state_o, 4);
    step(S);     chk("R10 retry done", state_o, 0);

    // R10 latch mode never expires
    retry_mode = 0; pulse_start(); oc_active = 1; step(S); oc_active = 0;
    step(C + 5); chk("R10 latch mode", state_o, 5);
    uv_clr = 1; cyc(); uv_clr = 0; chk("R9 final clear", state_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule